// File: doc/BRIEF.md
# Dual-Bus Command Snooper and Bit Striper

This block is the byte path between the transmit and receive queues of a flash-oriented SPI controller and up to `NUM_BUS` parallel byte-transfer engines. Each transfer takes bytes from the head of the transmit queue and hands one byte to every active bus. When every active bus has returned a byte, the block pushes the received data into the receive queue. The serial shifters, the queue storage and the chip-select logic are outside the block. They appear only as ports.

While a command header is in flight, the block copies each byte to all active buses. The receive queue keeps only what bus 0 returns. The first byte after chip select goes active is taken as the flash opcode. The opcode sets how many more header bytes follow. After those bytes, the block enters a striping mode. In striping mode one byte per bus is taken from the queue and its bits are interleaved across the buses. The received bytes are de-interleaved and all of them are pushed.

Top module: `spi_lane_striper`

## Requirements
- R1: After reset the block is idle (`busy`=0), not striping (`striping`=0), and pops nothing. The command tracker waits for an opcode.
- R2: The first completed transfer after the tracker waits for an opcode loads a header count from byte 0. 0x03, 0x02, 0xA2 and 0x32 give 3. 0x0B, 0x3B, 0x6B and 0xBB give 4. 0xEB gives 6. Each later completed transfer lowers the count by one. When the count reaches zero, `striping` rises one cycle after the completion.
- R3: Any other opcode puts the tracker in a passthrough state. `striping` then stays 0 until the tracker waits for an opcode again. Once `striping` is 1, it stays 1 while `cs_active` is high.
- R4: A cycle with `cs_active` low makes the tracker wait for an opcode. `striping` is 0 on the next cycle.
- R5: When not striping, a transfer pops 1 byte and drives `tx_data[7:0]` on every active lane. It pushes 1 byte, the lane-0 return, on `rx_data[7:0]`.
- R6: When striping with both lanes active, a transfer pops `NUM_BUS` bytes. The input stream bit k is bit k of `tx_data`, which is byte k/8, bit k%8. Bit j of lane b's output byte (`bus_tx_data[b*8+j]`) is stream bit j*NUM_BUS+b.
- R7: When striping with both lanes active, the returned bytes are de-interleaved by the inverse map. Stream bit k = lane (k%NUM_BUS) bit (k/NUM_BUS). The result is pushed as `NUM_BUS` bytes, stream bit k at `rx_data[k]`.
- R8: With `dual_en`=0 only lane 0 is active. Striping is then the identity map (1 byte popped and pushed). Returns on other lanes are ignored.
- R9: If `rx_full` is high when a transfer completes, nothing is pushed and `overflow_evt` pulses. The header count still advances.
- R10: Suppose `go` is high while idle and `tx_avail` is below the bytes the transfer needs. Then nothing is popped or sent, and `underflow_evt` pulses, unless `linear_mode` is high.
- R11: A transfer starts only in a cycle where every active lane's `bus_ready` is high. It completes, with push or overflow combinational in that cycle, in the cycle the last active lane returns a byte, in any lane order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_en | input | 1 | 1: all NUM_BUS lanes active; 0: lane 0 only |
| linear_mode | input | 1 | Suppresses the underflow event |
| cs_active | input | 1 | High while any chip select is asserted |
| go | input | 1 | Request a transfer while idle |
| tx_avail | input | $clog2(NUM_BUS+1) | Number of valid head bytes on tx_data |
| tx_data | input | NUM_BUS*8 | Transmit queue head bytes, byte 0 in bits 7:0 |
| tx_pop | output | 1 | Pop strobe for the transmit queue |
| tx_pop_cnt | output | $clog2(NUM_BUS+1) | Bytes popped with tx_pop |
| bus_ready | input | NUM_BUS | Lane engine can accept a byte |
| bus_tx_valid | output | NUM_BUS | Byte issued to lane |
| bus_tx_data | output | NUM_BUS*8 | Byte for each lane, lane b in bits b*8+7:b*8 |
| bus_rx_valid | input | NUM_BUS | Lane returns a byte |
| bus_rx_data | input | NUM_BUS*8 | Returned byte for each lane |
| rx_full | input | 1 | Receive queue is full |
| rx_push | output | 1 | Push strobe for the receive queue |
| rx_push_cnt | output | $clog2(NUM_BUS+1) | Bytes pushed with rx_push |
| rx_data | output | NUM_BUS*8 | Pushed bytes, byte 0 in bits 7:0 |
| underflow_evt | output | 1 | Transmit underflow pulse |
| overflow_evt | output | 1 | Receive overflow pulse |
| striping | output | 1 | Tracker is in striping mode |
| busy | output | 1 | A transfer is waiting for lane returns |

## Verification
The hardest state to reach is the end of a long header with the lanes returning out of order. An example is the sixth byte after 0xEB, where lane 1 answers before lane 0 and the receive queue is full. The bench reaches it by mixing directed opcode sequences with a random run of several hundred transfers. In that run the lane return delays are drawn independently, `rx_full` and `dual_en` vary, and chip select drops at random between transfers. A bench model of the tracker predicts the mode of every transfer, so each striped and unstriped byte is checked against a reference interleave.

// File: rtl/spi_lane_striper.sv
module spi_lane_striper #(
  parameter int NUM_BUS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               dual_en,
  input  logic                               linear_mode,
  input  logic                               cs_active,
  input  logic                               go,
  input  logic [$clog2(NUM_BUS+1)-1:0]       tx_avail,
  input  logic [NUM_BUS*8-1:0]               tx_data,
  output logic                               tx_pop,
  output logic [$clog2(NUM_BUS+1)-1:0]       tx_pop_cnt,
  input  logic [NUM_BUS-1:0]                 bus_ready,
  output logic [NUM_BUS-1:0]                 bus_tx_valid,
  output logic [NUM_BUS*8-1:0]               bus_tx_data,
  input  logic [NUM_BUS-1:0]                 bus_rx_valid,
  input  logic [NUM_BUS*8-1:0]               bus_rx_data,
  input  logic                               rx_full,
  output logic                               rx_push,
  output logic [$clog2(NUM_BUS+1)-1:0]       rx_push_cnt,
  output logic [NUM_BUS*8-1:0]               rx_data,
  output logic                               underflow_evt,
  output logic                               overflow_evt,
  output logic                               striping,
  output logic                               busy
);
  localparam int CW = $clog2(NUM_BUS+1);
  localparam int SW = NUM_BUS*8;

  typedef enum logic [1:0] {SN_CHECK, SN_NONE, SN_COUNT, SN_STRIPE} snoop_t;

  snoop_t             snoop_q, snoop_d;
  logic [2:0]         cnt_q, cnt_d;
  logic               wait_q;
  logic               x_dual_q, x_stripe_q;
  logic [7:0]         x_op_q;
  logic [NUM_BUS-1:0] got_q;
  logic [SW-1:0]      cap_q;

  logic               dual_eff;
  logic [NUM_BUS-1:0] lane_mask, x_mask, rx_got;
  logic [CW-1:0]      need;
  logic               enough, all_ready, issue, done, wide_x;
  logic [SW-1:0]      st_tx, merged, us_rx;

  assign dual_eff  = dual_en && (NUM_BUS > 1);
  assign lane_mask = dual_eff ? '1 : NUM_BUS'(1);
  assign x_mask    = x_dual_q ? '1 : NUM_BUS'(1);
  assign striping  = (snoop_q == SN_STRIPE);
  assign busy      = wait_q;

  assign need      = (striping && dual_eff) ? CW'(NUM_BUS) : CW'(1);
  assign enough    = (tx_avail >= need);
  assign all_ready = &(bus_ready | ~lane_mask);
  assign issue     = !wait_q && go && enough && all_ready;

  assign tx_pop        = issue;
  assign tx_pop_cnt    = issue ? need : '0;
  assign underflow_evt = !wait_q && go && !enough && !linear_mode;
  assign bus_tx_valid  = issue ? lane_mask : '0;

  always_comb begin
    for (int b = 0; b < NUM_BUS; b++)
      for (int j = 0; j < 8; j++)
        st_tx[b*8+j] = tx_data[j*NUM_BUS+b];
  end

  assign bus_tx_data = (striping && dual_eff) ? st_tx : {NUM_BUS{tx_data[7:0]}};

  always_comb begin
    for (int b = 0; b < NUM_BUS; b++)
      merged[b*8 +: 8] = bus_rx_valid[b] ? bus_rx_data[b*8 +: 8] : cap_q[b*8 +: 8];
  end

  always_comb begin
    for (int k = 0; k < SW; k++)
      us_rx[k] = merged[(k % NUM_BUS)*8 + k / NUM_BUS];
  end

  assign rx_got      = got_q | (bus_rx_valid & x_mask);
  assign done        = wait_q && (&(rx_got | ~x_mask));
  assign wide_x      = x_stripe_q && x_dual_q;
  assign rx_data     = wide_x ? us_rx : {{(SW-8){1'b0}}, merged[7:0]};
  assign rx_push     = done && !rx_full;
  assign rx_push_cnt = rx_push ? (wide_x ? CW'(NUM_BUS) : CW'(1)) : '0;
  assign overflow_evt = done && rx_full;

  always_comb begin
    snoop_d = snoop_q;
    cnt_d   = cnt_q;
    if (done) begin
      case (snoop_q)
        SN_CHECK: begin
          case (x_op_q)
            8'h03, 8'h02, 8'hA2, 8'h32: begin snoop_d = SN_COUNT; cnt_d = 3'd3; end
            8'h0B, 8'h3B, 8'h6B, 8'hBB: begin snoop_d = SN_COUNT; cnt_d = 3'd4; end
            8'hEB:                      begin snoop_d = SN_COUNT; cnt_d = 3'd6; end
            default:                          snoop_d = SN_NONE;
          endcase
        end
        SN_COUNT: begin
          if (cnt_q == 3'd1) snoop_d = SN_STRIPE;
          cnt_d = cnt_q - 3'd1;
        end
        default: ;
      endcase
    end
    if (!cs_active) begin
      snoop_d = SN_CHECK;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snoop_q    <= SN_CHECK;
      cnt_q      <= '0;
      wait_q     <= 1'b0;
      x_dual_q   <= 1'b0;
      x_stripe_q <= 1'b0;
      x_op_q     <= '0;
      got_q      <= '0;
      cap_q      <= '0;
    end else begin
      snoop_q <= snoop_d;
      cnt_q   <= cnt_d;
      if (issue) begin
        wait_q     <= 1'b1;
        x_dual_q   <= dual_eff;
        x_stripe_q <= striping;
        x_op_q     <= tx_data[7:0];
        got_q      <= '0;
      end else if (done) begin
        wait_q <= 1'b0;
      end else if (wait_q) begin
        got_q <= rx_got;
        cap_q <= merged;
      end
    end
  end
endmodule

module lane_striper_chk #(
  parameter int NUM_BUS = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cs_active,
  input logic [NUM_BUS-1:0]           bus_ready,
  input logic [NUM_BUS-1:0]           bus_tx_valid,
  input logic                         tx_pop,
  input logic [$clog2(NUM_BUS+1)-1:0] tx_pop_cnt,
  input logic                         rx_push,
  input logic                         rx_full,
  input logic                         overflow_evt,
  input logic                         underflow_evt,
  input logic                         striping,
  input logic                         busy
);
  AST_SEND_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n) (bus_tx_valid & ~bus_ready) == '0); // R11
  AST_POP_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |=> busy); // R11
  AST_NO_POP_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) underflow_evt |-> (!tx_pop && bus_tx_valid == '0)); // R10
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !rx_full); // R9
  AST_OVERFLOW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) overflow_evt |-> !rx_push); // R9
  AST_CS_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !cs_active |=> !striping); // R4
  AST_STRIPE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (striping && cs_active) |=> striping); // R3
  AST_SINGLE_POP_UNSTRIPED: assert property (@(posedge clk) disable iff (!rst_n) (tx_pop && !striping) |-> tx_pop_cnt == 1); // R5
endmodule

bind spi_lane_striper lane_striper_chk #(.NUM_BUS(NUM_BUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .bus_ready(bus_ready),
  .bus_tx_valid(bus_tx_valid), .tx_pop(tx_pop), .tx_pop_cnt(tx_pop_cnt),
  .rx_push(rx_push), .rx_full(rx_full), .overflow_evt(overflow_evt),
  .underflow_evt(underflow_evt), .striping(striping), .busy(busy)
);

// File: tb/sim_spi_lane_striper.sv
module sim_spi_lane_striper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_en = 1'b1, linear_mode = 1'b0, cs_active = 1'b1, go = 1'b0;
  logic [1:0]  tx_avail = 2'd2;
  logic [15:0] tx_data = '0;
  logic        tx_pop;
  logic [1:0]  tx_pop_cnt;
  logic [1:0]  bus_ready = 2'b11;
  logic [1:0]  bus_tx_valid;
  logic [15:0] bus_tx_data;
  logic [1:0]  bus_rx_valid = '0;
  logic [15:0] bus_rx_data = '0;
  logic        rx_full = 1'b0;
  logic        rx_push;
  logic [1:0]  rx_push_cnt;
  logic [15:0] rx_data;
  logic        underflow_evt, overflow_evt, striping, busy;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  int m_state = 0;
  int m_cnt = 0;

  spi_lane_striper #(.NUM_BUS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .linear_mode(linear_mode),
    .cs_active(cs_active), .go(go), .tx_avail(tx_avail), .tx_data(tx_data),
    .tx_pop(tx_pop), .tx_pop_cnt(tx_pop_cnt), .bus_ready(bus_ready),
    .bus_tx_valid(bus_tx_valid), .bus_tx_data(bus_tx_data),
    .bus_rx_valid(bus_rx_valid), .bus_rx_data(bus_rx_data), .rx_full(rx_full),
    .rx_push(rx_push), .rx_push_cnt(rx_push_cnt), .rx_data(rx_data),
    .underflow_evt(underflow_evt), .overflow_evt(overflow_evt),
    .striping(striping), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] ref_stripe(input logic [15:0] x);
    logic [15:0] r;
    for (int b = 0; b < 2; b++)
      for (int j = 0; j < 8; j++)
        r[b*8+j] = x[j*2+b];
    return r;
  endfunction

  function automatic logic [15:0] ref_unstripe(input logic [15:0] y);
    logic [15:0] r;
    for (int k = 0; k < 16; k++)
      r[k] = y[(k % 2)*8 + k / 2];
    return r;
  endfunction

  function automatic int ref_load(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: return 3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: return 4;
      8'hEB: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_done(input logic [7:0] op);
    if (m_state == 0) begin
      m_cnt = ref_load(op);
      m_state = (m_cnt == 0) ? 1 : 2;
    end else if (m_state == 2) begin
      m_cnt--;
      if (m_cnt == 0) m_state = 3;
    end
  endtask

  task automatic drop_cs();
    @(negedge clk);
    cs_active = 1'b0;
    @(negedge clk);
    cs_active = 1'b1;
    m_state = 0;
    m_cnt = 0;
    #1;
    check(striping == 1'b0, "R4 cs drop clears striping", striping, 0);
  endtask

  task automatic xfer(input bit dual, input logic [15:0] txd, input logic [15:0] rxd,
                      input bit full, input int d0, input int d1);
    bit es;
    int last;
    logic [15:0] exp_tx, exp_rx;
    es = (m_state == 3);
    last = (dual && d1 > d0) ? d1 : d0;
    dual_en = dual; tx_data = txd; tx_avail = 2'd2; go = 1'b1;
    bus_ready = 2'b11; rx_full = full; bus_rx_data = rxd;
    #1;
    exp_tx = (es && dual) ? ref_stripe(txd) : {txd[7:0], txd[7:0]};
    check(tx_pop == 1'b1 && tx_pop_cnt == ((es && dual) ? 2'd2 : 2'd1),
          es ? (dual ? "R6 pop count" : "R8 pop count") : "R5 pop count",
          {tx_pop, tx_pop_cnt}, {1'b1, ((es && dual) ? 2'd2 : 2'd1)});
    check(bus_tx_valid == (dual ? 2'b11 : 2'b01), "R11 lane valid", bus_tx_valid, dual ? 2'b11 : 2'b01);
    if (dual)
      check(bus_tx_data == exp_tx, es ? "R6 striped tx" : "R5 broadcast tx", bus_tx_data, exp_tx);
    else
      check(bus_tx_data[7:0] == txd[7:0], "R8 single lane tx", bus_tx_data[7:0], txd[7:0]);
    @(negedge clk);
    go = 1'b0;
    for (int c = 1; c <= last; c++) begin
      bus_rx_valid[0] = (c == d0);
      bus_rx_valid[1] = (c == d1);
      #1;
      if (c < last) begin
        check(rx_push == 1'b0 && overflow_evt == 1'b0 && busy == 1'b1, "R11 waits for all lanes",
              {busy, rx_push, overflow_evt}, 3'b100);
      end else if (full) begin
        check(overflow_evt == 1'b1 && rx_push == 1'b0, "R9 overflow drops data",
              {overflow_evt, rx_push}, 2'b10);
      end else begin
        exp_rx = (es && dual) ? ref_unstripe(rxd) : {8'h00, rxd[7:0]};
        check(rx_push == 1'b1 && rx_push_cnt == ((es && dual) ? 2'd2 : 2'd1),
              (es && dual) ? "R7 push count" : "R5 push count",
              {rx_push, rx_push_cnt}, {1'b1, ((es && dual) ? 2'd2 : 2'd1)});
        if (es && dual)
          check(rx_data == exp_rx, "R7 unstriped rx", rx_data, exp_rx);
        else
          check(rx_data[7:0] == exp_rx[7:0], dual ? "R5 lane0 rx" : "R8 single lane rx", rx_data[7:0], exp_rx[7:0]);
      end
      @(negedge clk);
    end
    bus_rx_valid = '0;
    rx_full = 1'b0;
    model_done(txd[7:0]);
    #1;
    check(striping == (m_state == 3), "R2 snoop mode", striping, (m_state == 3));
    check(busy == 1'b0, "R11 idle after completion", busy, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] ops [10];
    ops = '{8'h03, 8'h02, 8'hA2, 8'h32, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'h9F};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    check(striping == 1'b0 && busy == 1'b0 && tx_pop == 1'b0, "R1 reset state",
          {striping, busy, tx_pop}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(striping == 1'b0 && busy == 1'b0, "R1 after reset", {striping, busy}, 0);

    // R2: 0x03 needs three more header bytes
    xfer(1, 16'hAA03, 16'h1234, 0, 1, 1);
    xfer(1, 16'h0011, 16'h5555, 0, 2, 1);
    xfer(1, 16'h0022, 16'h6666, 0, 1, 2);
    check(striping == 1'b0, "R2 not yet striping", striping, 0);
    xfer(1, 16'h0033, 16'h7777, 0, 1, 1);
    check(striping == 1'b1, "R2 striping after header", striping, 1);
    xfer(1, 16'hF00F, 16'hA5C3, 0, 3, 1);
    xfer(1, 16'h8001, 16'h0180, 0, 1, 3);
    // R8: single lane while striping is identity, lane 1 returns ignored
    xfer(0, 16'h3C5A, 16'hFFE7, 0, 2, 1);
    // R10: underflow in striping with one byte on dual lanes
    @(negedge clk);
    dual_en = 1'b1; tx_avail = 2'd1; go = 1'b1;
    #1;
    check(underflow_evt == 1'b1 && tx_pop == 1'b0 && bus_tx_valid == 2'b00, "R10 short striping underflow",
          {underflow_evt, tx_pop, bus_tx_valid}, 4'b1000);
    linear_mode = 1'b1;
    #1;
    check(underflow_evt == 1'b0 && tx_pop == 1'b0, "R10 linear mode suppresses", {underflow_evt, tx_pop}, 0);
    linear_mode = 1'b0; go = 1'b0;
    drop_cs();
    // R10: empty queue while waiting for opcode
    @(negedge clk);
    tx_avail = 2'd0; go = 1'b1;
    #1;
    check(underflow_evt == 1'b1 && tx_pop == 1'b0, "R10 empty underflow", {underflow_evt, tx_pop}, 2'b10);
    go = 1'b0;
    // R11: lane 1 not ready blocks issue
    @(negedge clk);
    tx_avail = 2'd2; tx_data = 16'h00EB; bus_ready = 2'b01; go = 1'b1;
    #1;
    check(tx_pop == 1'b0 && bus_tx_valid == 2'b00, "R11 wait for ready", {tx_pop, bus_tx_valid}, 0);
    @(negedge clk);
    #1;
    check(busy == 1'b0, "R11 no transfer started", busy, 0);
    go = 1'b0;
    // R2: 0xEB needs six more bytes; R9 overflow mid-header still advances
    xfer(1, 16'h00EB, 16'h0101, 0, 1, 1);
    for (int i = 0; i < 5; i++) begin
      xfer(1, 16'(i), 16'h2020, (i == 2), 1, 2);
      check(striping == 1'b0, "R2 0xEB header", striping, 0);
    end
    xfer(1, 16'h0005, 16'h3030, 0, 2, 2);
    check(striping == 1'b1, "R2 0xEB striping", striping, 1);
    xfer(1, 16'hBEEF, 16'hCAFE, 1, 1, 1);
    drop_cs();
    // R3: unknown opcode never stripes
    xfer(1, 16'h009F, 16'h4444, 0, 1, 1);
    for (int i = 0; i < 8; i++) begin
      xfer(1, 16'(8'h03 + i), 16'h9999, 0, 1, 1);
      check(striping == 1'b0, "R3 passthrough holds", striping, 0);
    end
    drop_cs();
    xfer(1, 16'h000B, 16'h1111, 0, 1, 1);
    for (int i = 0; i < 4; i++) xfer(1, 16'h0000, 16'h2222, 0, 1, 1);
    check(striping == 1'b1, "R2 0x0B after four bytes", striping, 1);
    drop_cs();

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] t;
      t = 16'($urandom);
      if (m_state == 0) t[7:0] = ops[$urandom_range(9, 0)];
      xfer(($urandom_range(9, 0) != 0), t, 16'($urandom), ($urandom_range(9, 0) == 0),
           $urandom_range(3, 1), $urandom_range(3, 1));
      if ($urandom_range(24, 0) == 0) drop_cs();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule